// File: doc/BRIEF.md
# Sigma-Delta Bitstream Decimator (three-stage CIC chain)

This block turns the one-bit output of a second-order sigma-delta modulator into multi-bit audio samples. It uses no multipliers. Each modulator bit is first mapped to a signed unit value. Three cascaded integrator-comb decimators then lower the rate by 16, by 3 and by 2, for an overall ratio of 96. The stages have orders 5, 3 and 3.

Each stage integrates at its own input rate. It differentiates only on the samples it keeps. Its comb delay is one kept sample. Between stages, low-order bits are dropped by floor truncation. The last stage output is scaled down and converted to sign-and-magnitude form.

The whole chain runs on the oversampling clock. Each later stage advances only on the one-cycle valid pulse from the stage before it.

Top module: `sd_decim_chain`

## Requirements
- R1: Input bit 1 enters the chain as +1 and bit 0 as -1. A constant all-ones stream settles to `sample_o` = {sign 0, magnitude 13824}. A constant all-zeros stream settles to {sign 1, magnitude 13824}. The value 13824 is the DC gain 16^5·27·8 reduced by the 2^14 total truncation.
- R2: `valid_o` is high for exactly one clock in every 96 clocks of continuous input.
- R3: After reset is released, the first rising edge counts as edge 0. The first `valid_o` pulse becomes visible after edge 98, that is, after 99 rising edges. It carries the sample taken at edge 95.
- R4: Each output sample equals the following reference. Stage 1 is a fifth-order length-16 box filter over the ±1 stream, sampled on every 16th input. Its result is floor-divided by 2^4. Stage 2 is a third-order length-3 box filter, sampled every 3rd, then floor-divided by 2^3. Stage 3 is a third-order length-2 box filter, sampled every 2nd, then floor-divided by 2^7. Each stage is delayed by its order in input samples. Inputs before reset are taken as zero.
- R5: A constant alternating 1010… stream settles to an output of 0, with sign bit 0.
- R6: `sample_o[14]` is the sign (1 = negative) and `sample_o[13:0]` is the magnitude. The magnitude is clamped at 16383. A zero value never carries sign 1.
- R7: Asserting `rst_ni` low clears `valid_o` and `sample_o` at once and restarts all integrators, comb delays and rate counters.
- R8: `sample_o` changes only in a cycle where `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock; one modulator bit per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Modulator output bit |
| valid_o | output | 1 | One-cycle strobe at the output rate |
| sample_o | output | 15 | Sign bit [14] and 14-bit magnitude [13:0] |

## Verification
The bench builds the chain with its default values: orders 5/3/3, rates 16/3/2 and bit drops 4/3/7. It compares every clock against a behavioural model in the bench, written as recursive moving sums. That model is built differently from the integrate-then-comb hardware.

These values put the DC code at 13824, below the 14-bit ceiling, so the clamp is never reached. Long pseudo-random and pulse-density streams run stage-1 integrators through many two's-complement wraps. Mid-run reset exercises the full 99-edge fill latency a second time.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Register width needed by a CIC stage so that the final comb result is exact
  function automatic int unsigned acc_width(input int unsigned in_w,
                                            input int unsigned order,
                                            input int unsigned rate);
    return in_w + order * $clog2(rate);
  endfunction
endpackage

// File: rtl/cic_stage.sv
module cic_stage #(
  parameter int unsigned ORDER = 5,
  parameter int unsigned RATE  = 16,
  parameter int unsigned IN_W  = 2,
  parameter int unsigned ACC_W = 22
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic signed [IN_W-1:0]  in_data_i,
  output logic                    out_valid_o,
  output logic signed [ACC_W-1:0] out_data_o
);
  localparam int unsigned CNT_W = (RATE > 1) ? $clog2(RATE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RATE - 1);

  logic [CNT_W-1:0]        cnt_q;
  logic                    tick;
  logic signed [ACC_W-1:0] in_ext;
  logic signed [ACC_W-1:0] integ_q [ORDER];
  logic signed [ACC_W-1:0] dly_q   [ORDER];
  logic signed [ACC_W-1:0] comb_in [ORDER];
  logic signed [ACC_W-1:0] comb_acc;
  logic                    out_valid_q;
  logic signed [ACC_W-1:0] out_data_q;

  assign in_ext = ACC_W'(in_data_i);
  assign tick   = in_valid_i && (cnt_q == CNT_LAST);

  // rate divider counts accepted input samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (in_valid_i) cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
  end

  // registered integrator chain, wraps in two's complement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(ORDER); k++) integ_q[k] <= '0;
    end else if (in_valid_i) begin
      integ_q[0] <= integ_q[0] + in_ext;
      for (int k = 1; k < int'(ORDER); k++) integ_q[k] <= integ_q[k] + integ_q[k-1];
    end
  end

  // comb chain evaluated only on kept samples, delay of one kept sample
  always_comb begin
    comb_acc = integ_q[ORDER-1];
    for (int k = 0; k < int'(ORDER); k++) begin
      comb_in[k] = comb_acc;
      comb_acc   = comb_acc - dly_q[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(ORDER); k++) dly_q[k] <= '0;
    end else if (tick) begin
      for (int k = 0; k < int'(ORDER); k++) dly_q[k] <= comb_in[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= tick;
      if (tick) out_data_q <= comb_acc;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;

  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_q |=> !out_valid_q); // R2

  AST_STROBE_FROM_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_q |-> $past(in_valid_i)); // R2

  AST_DATA_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_data_q) |-> out_valid_q); // R8
endmodule

// File: rtl/sm_format.sv
module sm_format #(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned SHIFT = 7,
  parameter int unsigned MAG_W = 14
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic signed [IN_W-1:0] in_data_i,
  output logic                   valid_o,
  output logic [MAG_W:0]         data_o
);
  localparam int unsigned TW = IN_W - SHIFT;
  localparam logic [TW:0] MAX_MAG = (TW+1)'((64'd1 << MAG_W) - 64'd1);

  logic signed [TW-1:0] scaled;
  logic [TW:0]          ext, abs_v;
  logic                 neg, sat;
  logic [MAG_W-1:0]     mag;
  logic                 unused_lsb;
  logic                 valid_q;
  logic [MAG_W:0]       data_q;

  assign scaled     = in_data_i[IN_W-1:SHIFT];
  assign unused_lsb = ^in_data_i[SHIFT-1:0];
  assign neg        = scaled[TW-1];
  assign ext        = {scaled[TW-1], scaled};
  assign abs_v      = neg ? (~ext + (TW+1)'(1)) : ext;
  assign sat        = abs_v > MAX_MAG;
  assign mag        = sat ? MAX_MAG[MAG_W-1:0] : abs_v[MAG_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= in_valid_i;
      if (in_valid_i) data_q <= {neg, mag};
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  AST_NO_NEG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_q[MAG_W] |-> (data_q[MAG_W-1:0] != '0)); // R6

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_q) |-> valid_q); // R8

  AST_OUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R2
endmodule

// File: rtl/sd_decim_chain.sv
module sd_decim_chain
  import cic_pkg::*;
#(
  parameter int unsigned S1_ORDER = 5,
  parameter int unsigned S1_RATE  = 16,
  parameter int unsigned S1_DROP  = 4,
  parameter int unsigned S2_ORDER = 3,
  parameter int unsigned S2_RATE  = 3,
  parameter int unsigned S2_DROP  = 3,
  parameter int unsigned S3_ORDER = 3,
  parameter int unsigned S3_RATE  = 2,
  parameter int unsigned OUT_DROP = 7,
  parameter int unsigned MAG_W    = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  output logic             valid_o,
  output logic [MAG_W:0]   sample_o
);
  localparam int unsigned LVL_W = 2;
  localparam int unsigned W1    = acc_width(LVL_W, S1_ORDER, S1_RATE);
  localparam int unsigned W2_IN = W1 - S1_DROP;
  localparam int unsigned W2    = acc_width(W2_IN, S2_ORDER, S2_RATE);
  localparam int unsigned W3_IN = W2 - S2_DROP;
  localparam int unsigned W3    = acc_width(W3_IN, S3_ORDER, S3_RATE);

  logic signed [LVL_W-1:0] lvl;
  logic                    s1_v, s2_v, s3_v;
  logic signed [W1-1:0]    s1_d;
  logic signed [W2-1:0]    s2_d;
  logic signed [W3-1:0]    s3_d;
  logic signed [W2_IN-1:0] s2_in;
  logic signed [W3_IN-1:0] s3_in;
  logic                    unused_drop;

  // level shift: 1 -> +1, 0 -> -1
  assign lvl = bit_i ? 2'b01 : 2'b11;

  cic_stage #(.ORDER(S1_ORDER), .RATE(S1_RATE), .IN_W(LVL_W), .ACC_W(W1)) u_s1 (
    .clk_i, .rst_ni, .in_valid_i(1'b1), .in_data_i(lvl),
    .out_valid_o(s1_v), .out_data_o(s1_d));

  assign s2_in = s1_d[W1-1:S1_DROP];

  cic_stage #(.ORDER(S2_ORDER), .RATE(S2_RATE), .IN_W(W2_IN), .ACC_W(W2)) u_s2 (
    .clk_i, .rst_ni, .in_valid_i(s1_v), .in_data_i(s2_in),
    .out_valid_o(s2_v), .out_data_o(s2_d));

  assign s3_in = s2_d[W2-1:S2_DROP];

  cic_stage #(.ORDER(S3_ORDER), .RATE(S3_RATE), .IN_W(W3_IN), .ACC_W(W3)) u_s3 (
    .clk_i, .rst_ni, .in_valid_i(s2_v), .in_data_i(s3_in),
    .out_valid_o(s3_v), .out_data_o(s3_d));

  assign unused_drop = ^{s1_d[S1_DROP-1:0], s2_d[S2_DROP-1:0]};

  sm_format #(.IN_W(W3), .SHIFT(OUT_DROP), .MAG_W(MAG_W)) u_fmt (
    .clk_i, .rst_ni, .in_valid_i(s3_v), .in_data_i(s3_d),
    .valid_o, .data_o(sample_o));

  AST_CHAIN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(s3_v)); // R3
endmodule

// File: tb/sim_sd_decim_chain.sv
module sim_sd_decim_chain;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_i = 1'b0;
  logic        valid_o;
  logic [14:0] sample_o;

  always #10 clk_i = ~clk_i;

  sd_decim_chain u0 (.clk_i, .rst_ni, .bit_i, .valid_o, .sample_o);

  localparam int ORD  [3] = '{5, 3, 3};
  localparam int RAT  [3] = '{16, 3, 2};
  localparam int DROP [3] = '{4, 3, 7};

  int ms [3][6][32];
  int ncnt [3];
  int nchk = 0, nfail = 0;
  int iter, due, last_v;
  bit pend, seen, done;
  logic [14:0] exp_s, held;
  int lfsr = 16'hACE1, pdm_acc = 0, pdm_lvl = 0, pdm_dir = 1;
  bit alt = 1'b0;

  function automatic logic [14:0] enc(input int t);
    int m;
    m = (t < 0) ? -t : t;
    if (m > 16383) m = 16383;
    return {(t < 0), 14'(m)};
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 3; s++) begin
      ncnt[s] = 0;
      for (int k = 0; k < 6; k++) for (int j = 0; j < 32; j++) ms[s][k][j] = 0;
    end
  endtask

  // N cascaded moving sums of length R; output delayed by N samples
  task automatic stage_step(input int s, input int x, output bit got, output int y);
    int n, prv, old;
    n = ncnt[s];
    ms[s][0][n % 32] = x;
    for (int k = 1; k <= ORD[s]; k++) begin
      prv = (n > 0) ? ms[s][k][(n - 1) % 32] : 0;
      old = (n >= RAT[s]) ? ms[s][k-1][(n - RAT[s]) % 32] : 0;
      ms[s][k][n % 32] = prv + ms[s][k-1][n % 32] - old;
    end
    got = ((n % RAT[s]) == RAT[s] - 1);
    y = (n >= ORD[s]) ? ms[s][ORD[s]][(n - ORD[s]) % 32] : 0;
    ncnt[s] = n + 1;
  endtask

  task automatic model_step(input bit b);
    bit g;
    int y;
    stage_step(0, b ? 1 : -1, g, y);
    if (g) begin
      stage_step(1, y >>> DROP[0], g, y);
      if (g) begin
        stage_step(2, y >>> DROP[1], g, y);
        if (g) begin
          pend = 1'b1;
          due = iter + 4;
          exp_s = enc(y >>> DROP[2]);
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act %0d exp %0d (iter %0d)", req, what, act, expv, iter);
    end
  endtask

  task automatic check_cycle();
    bit ev;
    ev = pend && (due == iter);
    check(valid_o === ev, "R2", "valid_o", int'(valid_o), int'(ev));
    if (valid_o) begin
      if (!seen) check(iter == 99, "R3", "first valid iter", iter, 99);
      else       check(iter - last_v == 96, "R2", "valid spacing", iter - last_v, 96);
      seen = 1'b1;
      last_v = iter;
      check(!(sample_o[14] && sample_o[13:0] == 14'd0), "R6", "negative zero", int'(sample_o), 0);
    end
    if (ev) begin
      check(sample_o === exp_s, "R4", "sample", int'(sample_o), int'(exp_s));
      pend = 1'b0;
    end
    if (!valid_o) check(sample_o === held, "R8", "hold", int'(sample_o), int'(held));
    held = sample_o;
  endtask

  function automatic bit next_bit(input int mode);
    bit b;
    case (mode)
      0: begin alt = ~alt; b = alt; end
      1: b = 1'b1;
      2: b = 1'b0;
      3: begin
        b = lfsr[0];
        lfsr = (lfsr >> 1) ^ (lfsr[0] ? 16'hB400 : 16'h0);
      end
      default: begin
        pdm_lvl = pdm_lvl + pdm_dir;
        if (pdm_lvl >= 900 || pdm_lvl <= -900) pdm_dir = -pdm_dir;
        b = (pdm_acc >= 0);
        pdm_acc = pdm_acc + pdm_lvl + (b ? -1000 : 1000);
      end
    endcase
    return b;
  endfunction

  task automatic run(input int mode, input int count);
    bit b;
    for (int i = 0; i < count; i++) begin
      check_cycle();
      b = next_bit(mode);
      bit_i = b;
      model_step(b);
      @(negedge clk_i);
      iter++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(valid_o === 1'b0, "R7", "valid_o in reset", int'(valid_o), 0);
    check(sample_o === 15'd0, "R7", "sample_o in reset", int'(sample_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
    iter = 0; pend = 1'b0; seen = 1'b0; held = 15'd0; last_v = 0;
  endtask

  initial begin
    done = 1'b0;
    do_reset();
    run(0, 1152);
    check(held === 15'd0, "R5", "alternating settles", int'(held), 0);
    run(1, 1152);
    check(held === {1'b0, 14'd13824}, "R1", "all ones settles", int'(held), 13824);
    run(2, 1152);
    check(held === {1'b1, 14'd13824}, "R1", "all zeros settles", int'(held), 16384 + 13824);
    run(3, 4800);
    run(4, 9600);
    do_reset();
    run(1, 1152);
    check(held === {1'b0, 14'd13824}, "R7", "ones after mid reset", int'(held), 13824);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired act 0 exp 1");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule